// File: doc/BRIEF.md
# Tamper Input Debouncer

This block watches one asynchronous tamper pin and raises a detection strobe, one system clock long, whenever the pin moves into its active level and the selected filter accepts the move. The pin is first flipped by a polarity select so that the active level is always a logic 1 inside the block. It then passes through a two-flop synchronizer. Only after that does it reach the filter.

The filter has four behaviours. A bypass passes every synchronized edge. A stability filter accepts a new level only when four debounce ticks in a row have sampled it. An early-pass filter lets the first change through at once and then ignores further changes until the pin has been steady for four ticks. A vote filter takes the majority of the last three tick samples.

The debounce tick is a single-cycle pulse made inside the block by a free-running divider. A frequency select field sets the divider ratio. Every filter mode shares this one tick. All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `tamper_debounce_top`

## Requirements
- R1: With `deb_en` = 0, a move of the pin into its active level raises `detect` on the third rising clock edge after the change, which is the synchronizer latency plus one register.
- R2: `pol_high` = 1 makes a high pin active and `pol_high` = 0 makes a low pin active. Only a move into the active level produces a strobe. A move to the inactive level produces none.
- R3: After reset the filtered level is the inactive level. A pin held inactive through and after reset produces no strobe under either polarity.
- R4: `freq_sel` = k makes the debounce tick a one-cycle pulse every 2^(k+1) clock cycles. No two ticks are ever adjacent.
- R5: With `deb_en` = 1, `maj_en` = 0 and `async_en` = 0 (stability mode), the filtered level changes only on a tick. It changes only when that tick is the fourth consecutive tick sample of the new level. Shorter pulses produce no strobe.
- R6: With `deb_en` = 1, `maj_en` = 0 and `async_en` = 1 (early-pass mode), a change from an unblocked state is passed at once, with the same latency as R1. The block then ignores the pin until four consecutive tick samples agree.
- R7: With `deb_en` = 1 and `maj_en` = 1 (vote mode), the filtered level changes only on a tick. It becomes 1 when at least two of the last three tick samples are 1, and 0 otherwise.
- R8: When `maj_en` = 1, `async_en` has no effect. A pulse that early-pass mode would report but a vote would reject produces no strobe.
- R9: Each detection is a strobe of exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Raw asynchronous tamper pin |
| pol_high | input | 1 | 1: high level is active, 0: low level is active |
| deb_en | input | 1 | Enables filtering; 0 selects bypass |
| maj_en | input | 1 | Selects vote mode; overrides `async_en` |
| async_en | input | 1 | Selects early-pass mode instead of stability mode |
| freq_sel | input | SEL_W | Tick divider select; period is 2^(freq_sel+1) cycles |
| detect | output | 1 | One-cycle detection strobe |

## Verification
The bench builds the block with its default parameters: a 3-bit frequency select, a two-stage synchronizer, a four-tick stability window and a three-sample vote. Frequency select values 0 and 1 make the tick fast, so a four-tick window or a three-sample vote fits inside a few tens of cycles. This lets glitch trains, accepted pulses and early-pass hold-off all be exercised in short runs. A run at select value 3 makes the tick spacing long enough that a 40-cycle pulse cannot yet span four ticks, which shows the period scaling.

// File: rtl/tdb_pkg.sv
package tdb_pkg;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_SYNC   = 2'd1,
    MODE_ASYNC  = 2'd2,
    MODE_MAJ    = 2'd3
  } tdb_mode_e;

  // Vote mode wins over early-pass mode; filtering off wins over both.
  function automatic tdb_mode_e decode_mode(input logic en, input logic maj, input logic asy);
    if (!en)      return MODE_BYPASS;
    else if (maj) return MODE_MAJ;
    else if (asy) return MODE_ASYNC;
    else          return MODE_SYNC;
  endfunction

endpackage

// File: rtl/tdb_sync.sv
module tdb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tdb_tick_div.sv
module tdb_tick_div #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + CNT_W'(1);
  end

  // Low sel+1 bits all ones marks the last cycle of each period.
  always_comb begin
    mask = {CNT_W{1'b1}} >> (CNT_W - 1 - int'(sel));
    tick = ((cnt & mask) == mask);
  end

  a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/tdb_filter.sv
module tdb_filter
  import tdb_pkg::*;
#(
  parameter int STABLE_TICKS = 4,
  parameter int VOTE_N       = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  tdb_mode_e mode,
  input  logic      tick,
  input  logic      s,
  output logic      detect
);
  localparam int RUN_W = $clog2(STABLE_TICKS + 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(STABLE_TICKS);

  logic              lvl, lvl_n;
  logic              cand, cand_n, cand_t;
  logic [RUN_W-1:0]  run, run_n, run_t;
  logic              blocked, blocked_n;
  logic [VOTE_N-1:0] votes, votes_n, votes_t;
  logic              vote_lvl, stable_hit, detect_n;

  // Tick-sampled run tracker and vote window.
  always_comb begin
    if (s == cand) begin
      cand_t = cand;
      run_t  = (run == RUN_FULL) ? run : run + RUN_W'(1);
    end else begin
      cand_t = s;
      run_t  = RUN_W'(1);
    end
    votes_t    = {votes[VOTE_N-2:0], s};
    vote_lvl   = ($countones(votes_t) > (VOTE_N / 2));
    stable_hit = tick && (run_t == RUN_FULL);
  end

  always_comb begin
    lvl_n     = lvl;
    cand_n    = cand;
    run_n     = run;
    votes_n   = votes;
    blocked_n = 1'b0;
    if (tick) begin
      cand_n  = cand_t;
      run_n   = run_t;
      votes_n = votes_t;
    end
    unique case (mode)
      MODE_BYPASS: lvl_n = s;
      MODE_SYNC:   if (stable_hit) lvl_n = s;
      MODE_MAJ:    if (tick) lvl_n = vote_lvl;
      MODE_ASYNC: begin
        if (!blocked) begin
          if (s != lvl) begin
            lvl_n     = s;
            blocked_n = 1'b1;
            cand_n    = s;
            run_n     = '0;
          end
        end else begin
          blocked_n = !stable_hit;
        end
      end
      default: lvl_n = lvl;
    endcase
    detect_n = lvl_n & ~lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl     <= 1'b0;
      cand    <= 1'b0;
      run     <= RUN_FULL;
      blocked <= 1'b0;
      votes   <= '0;
      detect  <= 1'b0;
    end else begin
      lvl     <= lvl_n;
      cand    <= cand_n;
      run     <= run_n;
      blocked <= blocked_n;
      votes   <= votes_n;
      detect  <= detect_n;
    end
  end

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    detect |=> !detect);
  a_r1_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BYPASS && s && !lvl) |=> detect);
  a_r5_sync_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SYNC && !tick) |=> $stable(lvl));
  a_r7_vote_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_MAJ && !tick) |=> $stable(lvl));
  a_r6_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ASYNC && blocked) |=> $stable(lvl));
endmodule

// File: rtl/tamper_debounce_top.sv
module tamper_debounce_top
  import tdb_pkg::*;
#(
  parameter int SEL_W        = 3,
  parameter int SYNC_STAGES  = 2,
  parameter int STABLE_TICKS = 4,
  parameter int VOTE_N       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_raw,
  input  logic             pol_high,
  input  logic             deb_en,
  input  logic             maj_en,
  input  logic             async_en,
  input  logic [SEL_W-1:0] freq_sel,
  output logic             detect
);
  logic      act_raw;
  logic      act_s;
  logic      tick;
  tdb_mode_e mode;

  // Normalize before the synchronizer so reset zeros mean "inactive" for either polarity.
  assign act_raw = pol_high ? pin_raw : ~pin_raw;
  assign mode    = decode_mode(deb_en, maj_en, async_en);

  tdb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(act_raw), .q(act_s)
  );

  tdb_tick_div #(.SEL_W(SEL_W)) u_div (
    .clk(clk), .rst_n(rst_n), .sel(freq_sel), .tick(tick)
  );

  tdb_filter #(.STABLE_TICKS(STABLE_TICKS), .VOTE_N(VOTE_N)) u_filt (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick), .s(act_s), .detect(detect)
  );

  a_r8_vote_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (deb_en && maj_en) |-> (mode == MODE_MAJ));
endmodule

// File: tb/tamper_debounce_top_bench.sv
module tamper_debounce_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_raw = 1'b1;
  logic       pol_high = 1'b0;
  logic       deb_en = 1'b0;
  logic       maj_en = 1'b0;
  logic       async_en = 1'b0;
  logic [2:0] freq_sel = 3'd0;
  logic       detect;

  int checks = 0, fails = 0, strobes = 0, cyc = 0;
  string cur_req = "R3";
  bit done = 0;

  // Reference model state
  int m_s1, m_s2, m_cnt, m_lvl, m_cand, m_run, m_blk;
  int mv[$];
  bit exp_det;

  always #4 clk = ~clk;

  tamper_debounce_top u_tamper_debounce_top (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .pol_high(pol_high),
    .deb_en(deb_en), .maj_en(maj_en), .async_en(async_en),
    .freq_sel(freq_sel), .detect(detect)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_cnt = 0; m_lvl = 0; m_cand = 0; m_run = 4; m_blk = 0;
      mv = '{0, 0, 0};
      exp_det = 0;
    end else begin
      int act, s, per, nl, ones;
      bit tk, hit;
      act = pol_high ? int'(pin_raw) : int'(!pin_raw);
      s = m_s2; m_s2 = m_s1; m_s1 = act;
      per = 2 << freq_sel;
      tk = ((m_cnt % per) == per - 1);
      m_cnt = (m_cnt + 1) % 256;
      nl = m_lvl;
      if (tk) begin
        mv.push_back(s);
        void'(mv.pop_front());
        if (s == m_cand) m_run = (m_run < 4) ? m_run + 1 : 4;
        else begin m_cand = s; m_run = 1; end
      end
      hit = tk && (m_run == 4);
      if (!deb_en) begin
        nl = s; m_blk = 0;
      end else if (maj_en) begin
        ones = 0;
        foreach (mv[i]) ones += mv[i];
        if (tk) nl = (ones >= 2);
        m_blk = 0;
      end else if (async_en) begin
        if (m_blk == 0) begin
          if (s != m_lvl) begin nl = s; m_blk = 1; m_cand = s; m_run = 0; end
        end else if (hit) m_blk = 0;
      end else begin
        if (hit) nl = s;
        m_blk = 0;
      end
      exp_det = (nl == 1) && (m_lvl == 0);
      m_lvl = nl;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (detect !== exp_det) begin
        fails++;
        $display("FAIL %s cycle-compare: actual=%b expected=%b", cur_req, detect, exp_det);
      end
      if (detect === 1'b1) strobes++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int got, int expv);
    checks++;
    if (got != expv) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, expv);
    end
  endtask

  initial begin
    // R3: reset with active-low polarity, pin inactive (high)
    cycles(5);
    rst_n = 1'b1;
    chk("R3", int'(detect), 0);
    cycles(20);
    chk("R3", strobes, 0);

    // R1: bypass latency, active-low pin falls
    cur_req = "R1";
    strobes = 0;
    pin_raw = 1'b0;
    cycles(2); chk("R1", int'(detect), 0);
    cycles(1); chk("R1", int'(detect), 1);
    cycles(1); chk("R9", int'(detect), 0);
    // R2: return to inactive gives no strobe
    cur_req = "R2";
    pin_raw = 1'b1;
    cycles(10);
    chk("R2", strobes, 1);

    // R3: active-high polarity through reset
    rst_n = 1'b0; pol_high = 1'b1; pin_raw = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cur_req = "R3";
    strobes = 0;
    cycles(10);
    chk("R3", strobes, 0);

    // R2: three active-high pulses in bypass
    cur_req = "R2";
    for (int i = 0; i < 3; i++) begin
      pin_raw = 1'b1; cycles(3);
      pin_raw = 1'b0; cycles(3);
    end
    cycles(5);
    chk("R2", strobes, 3);

    // R5: stability mode, period 4
    cur_req = "R5";
    deb_en = 1'b1; freq_sel = 3'd1;
    cycles(20);
    strobes = 0;
    pin_raw = 1'b1; cycles(6);
    pin_raw = 1'b0; cycles(40);
    chk("R5", strobes, 0);
    pin_raw = 1'b1; cycles(40);
    chk("R5", strobes, 1);
    pin_raw = 1'b0; cycles(40);
    chk("R5", strobes, 1);

    // R4: period 16 stretches the four-tick window past 40 cycles
    cur_req = "R4";
    freq_sel = 3'd3;
    cycles(80);
    strobes = 0;
    pin_raw = 1'b1; cycles(40);
    chk("R4", strobes, 0);
    cycles(60);
    chk("R4", strobes, 1);
    pin_raw = 1'b0; cycles(100);

    // R6: early-pass mode, period 4
    cur_req = "R6";
    freq_sel = 3'd1; async_en = 1'b1;
    cycles(40);
    strobes = 0;
    for (int i = 0; i < 5; i++) begin
      pin_raw = 1'b1; cycles(3);
      pin_raw = 1'b0; cycles(3);
    end
    cycles(60);
    chk("R6", strobes, 1);
    pin_raw = 1'b1;
    cycles(2); chk("R6", int'(detect), 0);
    cycles(1); chk("R6", int'(detect), 1);
    cycles(1); chk("R9", int'(detect), 0);
    pin_raw = 1'b0; cycles(60);

    // R7: vote mode, period 2
    cur_req = "R7";
    async_en = 1'b0; maj_en = 1'b1; freq_sel = 3'd0;
    cycles(20);
    strobes = 0;
    pin_raw = 1'b1; cycles(2);
    pin_raw = 1'b0; cycles(20);
    chk("R7", strobes, 0);
    pin_raw = 1'b1; cycles(6);
    pin_raw = 1'b0; cycles(20);
    chk("R7", strobes, 1);

    // R8: early-pass bit ignored while vote mode is on
    cur_req = "R8";
    async_en = 1'b1;
    cycles(10);
    strobes = 0;
    pin_raw = 1'b1; cycles(2);
    pin_raw = 1'b0; cycles(20);
    chk("R8", strobes, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule